// File: doc/BRIEF.md
# Ring-Oscillator PUF Response Generator

This block derives a device-unique response word from manufacturing spread between nominally identical ring oscillators. It receives the raw outputs of N oscillators and drives their active-low enables itself. The oscillators are grouped into N/2 fixed pairs, and pair p always places oscillator p against oscillator p+N/2. For each pair, the block turns on the two oscillators for a window of reference-clock cycles and counts the rising edges of each one. The result bit records which oscillator of the pair ran faster.

A mask input, sampled on start, chooses which pairs are measured. The mask normally holds only pairs whose frequency gap is wide enough to stay stable across voltage and temperature. The block visits the chosen pairs in ascending order, packs the bits densely from bit 0 upward, reports how many bits it produced, and pulses done. Equal counts, including the case where both counters saturate, give a 0 bit and raise a tie flag that stays set until the next start.

Top module: `ro_puf_resp`

## Requirements
- R1: While reset is held, and after it is released until the first start, done, busy, tie, response and resp_len are all 0, and every osc_en_n line is 1 (all oscillators off).
- R2: Pair p compares oscillator p (top) against oscillator p+N/2 (bottom). Its bit is 1 when the top oscillator produced more rising edges in the window.
- R3: A pair's bit is 0 when the bottom oscillator produced more rising edges in the window.
- R4: A pair is measured only if its bit in the mask is 1. The oscillators of an unmasked pair are never enabled during the run.
- R5: Measured pairs are visited in ascending index order. The k-th measured bit (k from 0) lands at response bit k, all higher response bits are 0, and resp_len equals the number of 1 bits in the mask.
- R6: osc_en_n is active low. At any time at most two lines are low, and those are exactly the two oscillators of the pair being measured, only while its window is open.
- R7: For each measured pair, both enables are held low for exactly win_len reference-clock cycles. win_len is sampled on start and is at least 1.
- R8: Edge counters saturate at all ones. Equal counts, including both saturated, give a 0 bit and set tie, which stays set until the next start.
- R9: busy rises the cycle after an accepted start and falls the cycle after done. done is high for exactly one cycle. A start while busy is ignored. response, resp_len and tie hold their values until the next accepted start.
- R10: An all-zero mask completes with done, response 0 and resp_len 0, and enables no oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a response run when idle |
| mask | input | NUM_OSC/2 | Pair selection, bit p selects pair p |
| win_len | input | WIN_W | Window length in reference cycles |
| osc_in | input | NUM_OSC | Raw oscillator outputs, asynchronous |
| osc_en_n | output | NUM_OSC | Active-low oscillator enables |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| response | output | NUM_OSC/2 | Packed response bits, first measured at bit 0 |
| resp_len | output | $clog2(NUM_OSC/2+1) | Number of valid response bits |
| tie | output | 1 | Some measured pair gave equal counts |

## Verification
A wrong pair index shows up at the ports at once. The enable lines that go low at the start of a window name the oscillators being compared, so a slip in the pair walk appears in the first window cycle of the pair concerned. A miscounting or stale edge counter leaves the enables intact but flips a response bit or the tie flag, and that is visible only when done is pulsed. For that reason, the scenarios use pairs with clearly separated periods, one pair with identical periods, and one window long enough to drive both counters into saturation. A wrong window length is caught by counting how many cycles each enable line stays low.

// File: rtl/ro_puf_pkg.sv
package ro_puf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEEK = 3'd1,
    ST_RUN  = 3'd2,
    ST_CMP  = 3'd3,
    ST_DONE = 3'd4
  } puf_state_e;

  // Oscillator placed on the "top" side of pair p.
  function automatic int unsigned pair_top_idx(input int unsigned p);
    return p;
  endfunction

  // Partner oscillator, half the array away, for pair p.
  function automatic int unsigned pair_bot_idx(input int unsigned p, input int unsigned half);
    return p + half;
  endfunction

  // Result bit: top strictly faster than bottom.
  function automatic logic faster_top(input logic [31:0] n_top, input logic [31:0] n_bot);
    return n_top > n_bot;
  endfunction

  // Counts indistinguishable.
  function automatic logic counts_equal(input logic [31:0] n_top, input logic [31:0] n_bot);
    return n_top == n_bot;
  endfunction

  // A zero window length is promoted to a single cycle.
  function automatic logic [31:0] window_floor(input logic [31:0] w);
    return (w == 32'd0) ? 32'd1 : w;
  endfunction

endpackage

// File: rtl/ro_puf_sync_rise.sv
module ro_puf_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ro_puf_edge_ctr.sv
module ro_puf_edge_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  logic at_max;
  assign at_max = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && !at_max) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ro_puf_seq.sv
module ro_puf_seq
  import ro_puf_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int WIN_W     = 16,
  parameter int LEN_W     = $clog2(NUM_PAIRS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_PAIRS-1:0] mask,
  input  logic [WIN_W-1:0]     win_len,
  input  logic                 res_bit,
  input  logic                 res_tie,
  output logic [LEN_W-1:0]     pair_idx,
  output logic                 win_open,
  output logic                 bit_valid,
  output logic                 ctr_clr,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_PAIRS-1:0] response,
  output logic [LEN_W-1:0]     resp_len,
  output logic                 tie
);

  puf_state_e           state;
  logic [NUM_PAIRS-1:0] mask_q;
  logic [WIN_W-1:0]     win_q;
  logic [WIN_W-1:0]     win_ctr;
  logic [NUM_PAIRS-1:0] mask_shift;
  logic                 pair_hit;
  logic                 walk_end;
  logic [NUM_PAIRS-1:0] bit_word;

  assign mask_shift = mask_q >> pair_idx;
  assign pair_hit   = mask_shift[0];
  assign walk_end   = (pair_idx == LEN_W'(NUM_PAIRS));
  assign bit_word   = {{(NUM_PAIRS-1){1'b0}}, res_bit} << resp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mask_q   <= '0;
      win_q    <= '0;
      win_ctr  <= '0;
      pair_idx <= '0;
      response <= '0;
      resp_len <= '0;
      tie      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            mask_q   <= mask;
            win_q    <= WIN_W'(window_floor(32'(win_len)));
            pair_idx <= '0;
            response <= '0;
            resp_len <= '0;
            tie      <= 1'b0;
            state    <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (walk_end) begin
            state <= ST_DONE;
          end else if (pair_hit) begin
            win_ctr <= win_q - 1'b1;
            state   <= ST_RUN;
          end else begin
            pair_idx <= pair_idx + 1'b1;
          end
        end
        ST_RUN: begin
          if (win_ctr == '0) begin
            state <= ST_CMP;
          end else begin
            win_ctr <= win_ctr - 1'b1;
          end
        end
        ST_CMP: begin
          response <= response | bit_word;
          resp_len <= resp_len + 1'b1;
          tie      <= tie | res_tie;
          pair_idx <= pair_idx + 1'b1;
          state    <= ST_SEEK;
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign win_open  = (state == ST_RUN);
  assign bit_valid = (state == ST_CMP);
  assign ctr_clr   = (state == ST_SEEK);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

endmodule

// File: rtl/ro_puf_resp.sv
module ro_puf_resp
  import ro_puf_pkg::*;
#(
  parameter int NUM_OSC     = 8,
  parameter int CNT_W       = 8,
  parameter int WIN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [NUM_OSC/2-1:0]           mask,
  input  logic [WIN_W-1:0]               win_len,
  input  logic [NUM_OSC-1:0]             osc_in,
  output logic [NUM_OSC-1:0]             osc_en_n,
  output logic                           busy,
  output logic                           done,
  output logic [NUM_OSC/2-1:0]           response,
  output logic [$clog2(NUM_OSC/2+1)-1:0] resp_len,
  output logic                           tie
);

  localparam int HALF      = NUM_OSC / 2;
  localparam int NUM_PAIRS = HALF;
  localparam int SEL_W     = $clog2(NUM_OSC);
  localparam int LEN_W     = $clog2(NUM_PAIRS + 1);

  logic [NUM_OSC-1:0] rise_vec;
  logic [LEN_W-1:0]   pair_idx;
  logic [SEL_W-1:0]   top_sel;
  logic [SEL_W-1:0]   bot_sel;
  logic               win_open;
  logic               bit_valid;
  logic               ctr_clr;
  logic               rise_top;
  logic               rise_bot;
  logic [CNT_W-1:0]   cnt_top;
  logic [CNT_W-1:0]   cnt_bot;
  logic               res_bit;
  logic               res_tie;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
    ro_puf_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (osc_in[g]),
      .rise     (rise_vec[g])
    );
  end

  assign top_sel  = SEL_W'(pair_top_idx(int'(pair_idx)));
  assign bot_sel  = SEL_W'(pair_bot_idx(int'(pair_idx), HALF));
  assign rise_top = rise_vec[top_sel];
  assign rise_bot = rise_vec[bot_sel];

  always_comb begin
    osc_en_n = '1;
    if (win_open) begin
      osc_en_n[top_sel] = 1'b0;
      osc_en_n[bot_sel] = 1'b0;
    end
  end

  ro_puf_edge_ctr #(.CNT_W(CNT_W)) u_ctr_top (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .inc   (win_open & rise_top),
    .cnt   (cnt_top)
  );

  ro_puf_edge_ctr #(.CNT_W(CNT_W)) u_ctr_bot (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .inc   (win_open & rise_bot),
    .cnt   (cnt_bot)
  );

  assign res_bit = faster_top(32'(cnt_top), 32'(cnt_bot));
  assign res_tie = counts_equal(32'(cnt_top), 32'(cnt_bot));

  ro_puf_seq #(
    .NUM_PAIRS (NUM_PAIRS),
    .WIN_W     (WIN_W),
    .LEN_W     (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mask      (mask),
    .win_len   (win_len),
    .res_bit   (res_bit),
    .res_tie   (res_tie),
    .pair_idx  (pair_idx),
    .win_open  (win_open),
    .bit_valid (bit_valid),
    .ctr_clr   (ctr_clr),
    .busy      (busy),
    .done      (done),
    .response  (response),
    .resp_len  (resp_len),
    .tie       (tie)
  );

endmodule

// File: rtl/ro_puf_chk.sv
module ro_puf_chk #(
  parameter int NUM_OSC = 8,
  parameter int CNT_W   = 8,
  parameter int WIN_W   = 16,
  parameter int LEN_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [WIN_W-1:0]   win_len,
  input logic [NUM_OSC-1:0] osc_en_n,
  input logic [LEN_W-1:0]   resp_len,
  input logic               win_open,
  input logic               bit_valid,
  input logic [CNT_W-1:0]   cnt_top,
  input logic [CNT_W-1:0]   cnt_bot
);

  logic [WIN_W-1:0] win_cap;
  logic [WIN_W:0]   open_run;
  logic [WIN_W:0]   want_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cap  <= '0;
      open_run <= '0;
    end else begin
      if (start && !busy) win_cap <= win_len;
      open_run <= win_open ? open_run + 1'b1 : '0;
    end
  end

  assign want_run = (win_cap == '0) ? (WIN_W+1)'(1) : {1'b0, win_cap};

  AST_EN_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~osc_en_n) == 0) || ($countones(~osc_en_n) == 2)); // R6
  AST_EN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> (&osc_en_n)); // R6
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> (open_run == want_run)); // R7
  AST_CMP_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> bit_valid); // R7
  AST_TOP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && $past(win_open)) |-> (cnt_top >= $past(cnt_top))); // R8
  AST_BOT_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && (&cnt_bot)) |=> (&cnt_bot)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    resp_len <= LEN_W'(NUM_OSC/2)); // R5

endmodule

bind ro_puf_resp ro_puf_chk #(
  .NUM_OSC (NUM_OSC),
  .CNT_W   (CNT_W),
  .WIN_W   (WIN_W),
  .LEN_W   (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .win_len   (win_len),
  .osc_en_n  (osc_en_n),
  .resp_len  (resp_len),
  .win_open  (win_open),
  .bit_valid (bit_valid),
  .cnt_top   (cnt_top),
  .cnt_bot   (cnt_bot)
);

// File: tb/tb_ro_puf_resp.sv
`timescale 1ns/1ps
module tb_ro_puf_resp;

  localparam int CLK_PERIOD = 10;
  localparam int NOSC       = 8;
  localparam int NP         = NOSC / 2;
  localparam int CMAX       = 255;
  localparam int WDOG       = 5000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NP-1:0]   mask_i = '0;
  logic [15:0]     win_i = 16'd1;
  logic [NOSC-1:0] osc;
  logic [NOSC-1:0] osc_en_n;
  logic            busy, done, tie;
  logic [NP-1:0]   response;
  logic [2:0]      resp_len;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ro_puf_resp dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask_i), .win_len(win_i),
    .osc_in(osc), .osc_en_n(osc_en_n), .busy(busy), .done(done),
    .response(response), .resp_len(resp_len), .tie(tie)
  );

  // Half periods in ns; pair 2 is deliberately matched.
  function automatic real half_ns(input int i);
    case (i)
      0: return 12.13;  4: return 24.71;
      1: return 31.07;  5: return 14.93;
      2: return 17.37;  6: return 17.37;
      3: return 13.39;  7: return 27.77;
      default: return 20.0;
    endcase
  endfunction

  for (genvar g = 0; g < NOSC; g++) begin : g_osc
    logic o = 1'b0;
    always begin
      if (osc_en_n[g] !== 1'b0) begin
        o = 1'b0;
        @(osc_en_n[g]);
      end else begin
        #(half_ns(g));
        if (osc_en_n[g] === 1'b0) o = ~o;
      end
    end
    assign osc[g] = o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected edge count for oscillator i over a window, clipped at counter max.
  function automatic int est_cnt(input int i, input int win);
    real n;
    n = (win * CLK_PERIOD) / (2.0 * half_ns(i));
    return (n >= CMAX) ? CMAX : int'($floor(n));
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 response", response, 0);
    chk("R1 resp_len", resp_len, 0);
    chk("R1 tie", tie, 0);
    chk("R1 enables", osc_en_n, 8'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {busy, done, tie}, 0);
  endtask

  task automatic t_run(input string name, input logic [NP-1:0] m, input int win, input bit poke);
    int low_cnt [NOSC];
    int max_low = 0;
    int cyc = 0;
    bit fin = 1'b0;
    int k = 0;
    int exp_resp = 0;
    int exp_tie = 0;
    logic [NP-1:0] held;
    foreach (low_cnt[i]) low_cnt[i] = 0;
    @(negedge clk);
    mask_i = m; win_i = 16'(win); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mask_i = ~m;
    chk({name, " R9 busy after start"}, busy, 1);
    while (!fin && cyc < WDOG) begin
      for (int i = 0; i < NOSC; i++) if (osc_en_n[i] == 1'b0) low_cnt[i]++;
      if ($countones(~osc_en_n) > max_low) max_low = $countones(~osc_en_n);
      if (poke && cyc == 5) begin mask_i = '1; win_i = 16'd3; start = 1'b1; end
      if (poke && cyc == 6) start = 1'b0;
      if (done) fin = 1'b1;
      else begin @(negedge clk); cyc++; end
    end
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R9 watchdog %s actual=%0d expected=done", name, cyc);
      return;
    end
    for (int p = 0; p < NP; p++) begin
      if (m[p]) begin
        int ct = est_cnt(p, win);
        int cb = est_cnt(p + NP, win);
        if (ct == cb) exp_tie = 1;
        else if (ct > cb) exp_resp |= (1 << k);  // R2 / R3
        k++;
      end
    end
    chk({name, " R2 R3 R5 response"}, response, exp_resp);
    chk({name, " R5 resp_len"}, resp_len, k);
    chk({name, " R8 tie"}, tie, exp_tie);
    chk({name, " R6 at most two enables"}, (max_low <= 2) ? 1 : 0, 1);
    for (int i = 0; i < NOSC; i++) begin
      if (m[i % NP]) chk({name, " R7 window cycles"}, low_cnt[i], win);
      else chk({name, " R4 unmasked oscillator stayed off"}, low_cnt[i], 0);
    end
    held = response;
    @(negedge clk);
    chk({name, " R9 done single cycle"}, done, 0);
    chk({name, " R9 busy cleared"}, busy, 0);
    repeat (3) @(negedge clk);
    chk({name, " R9 response held"}, response, held);
  endtask

  initial begin
    t_reset();
    t_run("all_pairs", 4'b1111, 100, 1'b0);   // R2 R3 R8 tie on matched pair
    t_run("ends_only", 4'b1001, 60,  1'b0);   // R4 R5 packing
    t_run("middle",    4'b0110, 80,  1'b0);   // R3 R8
    t_run("odd_poke",  4'b1010, 40,  1'b1);   // R9 start ignored while busy
    t_run("empty",     4'b0000, 20,  1'b0);   // R10
    t_run("saturate",  4'b0001, 2000, 1'b0);  // R8 both counters full
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule